// File: doc/BRIEF.md
# Serial Bus Master Register Block

This block is the software-facing register file of a two-wire serial bus master. A host reads and writes it over a simple 32-bit bus with word-granular addressing. It holds the parameters of the next transaction: command code, register address, runtime and hardware device address, write data and clock settings. Setting a control bit hands the transaction to a separate wire-level engine, which reports completion back through a request/done handshake. The block keeps write-one-to-clear status flags and drives one maskable interrupt.

It also asks the engine to send a one-time device-mode initialisation sequence. A line-control register lets software drive the clock and data wires directly and read back their live levels. Start, soft reset and initialisation bits clear themselves when their action finishes. The transaction parameter registers are protected while a transfer is running: a write to them is dropped and a distinct load-busy flag is raised.

Word offsets used by the bus `addr` port: 0 control, 1 clock control, 2 interrupt enable, 3 status, 4 register address, 7 data, 9 line control, 10 device-mode control, 11 command, 12 device address. Every other offset reads 0, and writes to it are dropped.

Top module: `sbus_regif`

## Requirements
- R1: After `rst`, every register reads 0, except device-mode control, which reads 0x007C3E00 (mode data 0x7C in bits 23:16, mode register 0x3E in bits 15:8, device address 0x00 in bits 7:0). `irq`, `xfer_req`, `xfer_abort` and `init_req` are low.
- R2: Writing control with bit 7 = 1 (and bits 6 and 0 = 0) sets the start bit and drives `xfer_req` high from the next cycle. Start reads back as 1 in control bit 7 until a `xfer_done` pulse is sampled. Start then clears, and status bit 0 (done) is set.
- R3: A `xfer_done` sampled together with `xfer_err` also sets the following status bits:
  - bit 1 (error);
  - bits 11:8, which take the value of `xfer_err_data`;
  - bit 16, which takes the value of `xfer_err_ack`.
- R4: Writing the status register clears each implemented bit (0, 1, 2, 11:8, 16) written as 1, and leaves bits written as 0 unchanged. A flag set by hardware in the same cycle as its clear stays set.
- R5: While start is set, a write to the register-address, data, command or device-address register is dropped and sets status bit 2 (load busy). The register keeps its old value.
- R6: Writing control with bit 6 = 1 clears start and pulses `xfer_abort` high for exactly one cycle. It sets no status bit.
- R7: `irq` is registered. It is high one cycle after control bit 1 (global enable) is 1 and some status bit is 1 at a position also set in the interrupt-enable register. Interrupt enable stores only the implemented status positions.
- R8: Writing control with bit 0 = 1 starts a soft reset. Control bit 0 reads 1 for 4 cycles and then clears. During those cycles every other register returns to its R1 value and bus writes are dropped.
- R9: Writing device-mode control stores bits 23:0, which drive `init_word`. If bit 31 is 1, `init_req` rises, and bit 31 reads 1 until `init_done` is sampled.
- R10: Line-control bits 0 to 3 drive, in order, `sda_ovr_en`, `sda_ovr_lvl`, `scl_ovr_en` and `scl_ovr_lvl`. Bits 4 and 5 read the live `sda_in` and `scl_in`.
- R11: Clock control stores the divider in bits 7:0 and the data output delay in bits 10:8, driving `clk_div` and `sda_dly`. Its other bits read 0.
- R12: `rdata` is registered and updates in the cycle after `rd_en`. A `xfer_done` with `xfer_rd_vld` and without `xfer_err` loads `xfer_rdata` into the data register. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 4 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| irq | output | 1 | Interrupt |
| xfer_req | output | 1 | Transfer request to the engine (start bit) |
| xfer_abort | output | 1 | One-cycle abort pulse |
| xfer_cmd | output | 8 | Command code |
| xfer_regaddr | output | 8 | Target register address |
| xfer_rta | output | 8 | Runtime device address |
| xfer_hwa | output | 16 | Hardware device address |
| xfer_wdata | output | 32 | Write data for the engine |
| xfer_done | input | 1 | Engine finished the transfer |
| xfer_err | input | 1 | Transfer failed |
| xfer_err_data | input | 4 | Byte-error indication |
| xfer_err_ack | input | 1 | Acknowledge error |
| xfer_rd_vld | input | 1 | xfer_rdata is valid with done |
| xfer_rdata | input | 32 | Data read by the engine |
| init_req | output | 1 | Device-mode init request |
| init_word | output | 24 | Init sequence fields |
| init_done | input | 1 | Init sequence finished |
| clk_div | output | 8 | Clock divider |
| sda_dly | output | 3 | Data output delay |
| sda_ovr_en | output | 1 | Manual data drive enable |
| sda_ovr_lvl | output | 1 | Manual data level |
| scl_ovr_en | output | 1 | Manual clock drive enable |
| scl_ovr_lvl | output | 1 | Manual clock level |
| sda_in | input | 1 | Live data line |
| scl_in | input | 1 | Live clock line |

## Verification
The bench targets four failure modes.
- A write to a parameter register during a transfer: a design that lets it through would corrupt the data or command mid-flight and never raise load busy.
- A hardware done flag arriving in the same cycle as a software clear of that flag: a wrong priority would lose the completion.
- Soft reset: a wrong cycle count would release the control bit early or hold it too long, and leaky write gating would keep a value written during the reset.
- Abort, the error fields and the init handshake: errors here show up as a stuck request, a second abort cycle, or an interrupt raised without global enable.

// File: rtl/sbus_regif_pkg.sv
package sbus_regif_pkg;
  // word offsets
  localparam int W_CTRL = 0;
  localparam int W_CCR  = 1;
  localparam int W_INTE = 2;
  localparam int W_INTS = 3;
  localparam int W_RADR = 4;
  localparam int W_DATA = 7;
  localparam int W_LINE = 9;
  localparam int W_DMOD = 10;
  localparam int W_CMD  = 11;
  localparam int W_DAR  = 12;
  // control bit positions
  localparam int C_SRST  = 0;
  localparam int C_GIE   = 1;
  localparam int C_ABORT = 6;
  localparam int C_START = 7;
  // status bit positions
  localparam int S_DONE = 0;
  localparam int S_ERR  = 1;
  localparam int S_LBSY = 2;
  localparam int S_EDAT = 8;
  localparam int S_ACK  = 16;
  localparam int DM_GO  = 31;
  localparam logic [23:0] DM_RESET = 24'h7C3E00;

  typedef struct packed {
    logic       ack;
    logic [3:0] dbyte;
  } xfer_fault_t;
endpackage

// File: rtl/sbus_ctrl_seq.sv
module sbus_ctrl_seq #(
  parameter int SRST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic w_start,
  input  logic w_abort,
  input  logic w_gie,
  input  logic w_srst,
  input  logic done_ok,
  input  logic dm_wr,
  input  logic w_dm_go,
  input  logic init_done,
  output logic srst_q,
  output logic start_q,
  output logic gie_q,
  output logic abort_q,
  output logic init_q
);
  localparam int CW = (SRST_CYCLES > 1) ? $clog2(SRST_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SRST_CYCLES - 1);

  logic [CW-1:0] scnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      srst_q <= 1'b0;
      scnt   <= '0;
    end else if (srst_q) begin
      if (scnt == LAST) begin
        srst_q <= 1'b0;
        scnt   <= '0;
      end else begin
        scnt <= scnt + 1'b1;
      end
    end else if (ctrl_wr && w_srst) begin
      srst_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || srst_q) begin
      start_q <= 1'b0;
      gie_q   <= 1'b0;
      abort_q <= 1'b0;
      init_q  <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      if (done_ok) start_q <= 1'b0;
      if (init_done && init_q) init_q <= 1'b0;
      if (ctrl_wr && !w_srst) begin
        gie_q <= w_gie;
        if (w_abort) begin
          start_q <= 1'b0;
          abort_q <= 1'b1;
        end else if (w_start) begin
          start_q <= 1'b1;
        end
      end
      if (dm_wr && w_dm_go) init_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sbus_status.sv
module sbus_status
  import sbus_regif_pkg::*;
#(
  parameter int DW   = 32,
  parameter int EB_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_wr,
  input  logic          inte_wr,
  input  logic [DW-1:0] wdata,
  input  logic          set_done,
  input  logic          set_err,
  input  xfer_fault_t   fault,
  input  logic          set_lbsy,
  input  logic          gie,
  output logic [DW-1:0] ints_q,
  output logic [DW-1:0] inte_q,
  output logic          irq_q
);
  localparam logic [DW-1:0] MASK = DW'((1 << S_ACK) | (((1 << EB_W) - 1) << S_EDAT)
                                       | (1 << S_LBSY) | (1 << S_ERR) | (1 << S_DONE));

  logic [DW-1:0] setv, clrv;

  always_comb begin
    setv = '0;
    setv[S_DONE] = set_done;
    setv[S_ERR]  = set_err;
    setv[S_LBSY] = set_lbsy;
    if (set_err) begin
      setv[S_EDAT +: EB_W] = fault.dbyte[EB_W-1:0];
      setv[S_ACK]          = fault.ack;
    end
    clrv = clr_wr ? (wdata & MASK) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ints_q <= '0;
      inte_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ints_q <= (ints_q & ~clrv) | setv;
      if (inte_wr) inte_q <= wdata & MASK;
      irq_q  <= gie && |(ints_q & inte_q);
    end
  end
endmodule

// File: rtl/sbus_regif.sv
module sbus_regif
  import sbus_regif_pkg::*;
#(
  parameter int AW          = 4,
  parameter int DW          = 32,
  parameter int SRST_CYCLES = 4,
  parameter int DIV_W       = 8,
  parameter int DLY_W       = 3,
  parameter int EB_W        = 4,
  parameter int CMD_W       = 8,
  parameter int RA_W        = 8,
  parameter int RTA_W       = 8,
  parameter int HWA_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             irq,
  output logic             xfer_req,
  output logic             xfer_abort,
  output logic [CMD_W-1:0] xfer_cmd,
  output logic [RA_W-1:0]  xfer_regaddr,
  output logic [RTA_W-1:0] xfer_rta,
  output logic [HWA_W-1:0] xfer_hwa,
  output logic [DW-1:0]    xfer_wdata,
  input  logic             xfer_done,
  input  logic             xfer_err,
  input  logic [EB_W-1:0]  xfer_err_data,
  input  logic             xfer_err_ack,
  input  logic             xfer_rd_vld,
  input  logic [DW-1:0]    xfer_rdata,
  input  logic             init_done,
  output logic             init_req,
  output logic [23:0]      init_word,
  output logic [DIV_W-1:0] clk_div,
  output logic [DLY_W-1:0] sda_dly,
  output logic             sda_ovr_en,
  output logic             sda_ovr_lvl,
  output logic             scl_ovr_en,
  output logic             scl_ovr_lvl,
  input  logic             sda_in,
  input  logic             scl_in
);
  localparam int CCR_W = DIV_W + DLY_W;
  localparam int DAR_W = RTA_W + HWA_W;

  logic srst_q, start_q, gie_q, abort_q, init_q, eff_rst, wr_ok, done_ok;
  logic hit_ctrl, hit_ccr, hit_inte, hit_ints, hit_radr, hit_data;
  logic hit_line, hit_dmod, hit_cmd, hit_dar, param_hit, lbsy;
  logic [CCR_W-1:0] ccr_q;
  logic [RA_W-1:0]  radr_q;
  logic [DW-1:0]    data_q, ints_q, inte_q, rmux;
  logic [3:0]       line_q;
  logic [23:0]      dm_q;
  logic [CMD_W-1:0] cmd_q;
  logic [DAR_W-1:0] dar_q;
  xfer_fault_t      fault;

  assign eff_rst   = rst | srst_q;
  assign wr_ok     = wr_en & ~srst_q;
  assign done_ok   = xfer_done & start_q;
  assign hit_ctrl  = wr_ok && (addr == AW'(W_CTRL));
  assign hit_ccr   = wr_ok && (addr == AW'(W_CCR));
  assign hit_inte  = wr_ok && (addr == AW'(W_INTE));
  assign hit_ints  = wr_ok && (addr == AW'(W_INTS));
  assign hit_radr  = wr_ok && (addr == AW'(W_RADR));
  assign hit_data  = wr_ok && (addr == AW'(W_DATA));
  assign hit_line  = wr_ok && (addr == AW'(W_LINE));
  assign hit_dmod  = wr_ok && (addr == AW'(W_DMOD));
  assign hit_cmd   = wr_ok && (addr == AW'(W_CMD));
  assign hit_dar   = wr_ok && (addr == AW'(W_DAR));
  assign param_hit = hit_radr | hit_data | hit_cmd | hit_dar;
  assign lbsy      = param_hit & start_q;
  assign fault     = '{ack: xfer_err_ack, dbyte: xfer_err_data};

  sbus_ctrl_seq #(.SRST_CYCLES(SRST_CYCLES)) ctrl_i (
    .clk(clk), .rst(rst), .ctrl_wr(hit_ctrl),
    .w_start(wdata[C_START]), .w_abort(wdata[C_ABORT]),
    .w_gie(wdata[C_GIE]), .w_srst(wdata[C_SRST]),
    .done_ok(done_ok), .dm_wr(hit_dmod), .w_dm_go(wdata[DM_GO]),
    .init_done(init_done), .srst_q(srst_q), .start_q(start_q),
    .gie_q(gie_q), .abort_q(abort_q), .init_q(init_q)
  );

  sbus_status #(.DW(DW), .EB_W(EB_W)) stat_i (
    .clk(clk), .rst(eff_rst), .clr_wr(hit_ints), .inte_wr(hit_inte),
    .wdata(wdata), .set_done(done_ok), .set_err(done_ok & xfer_err),
    .fault(fault), .set_lbsy(lbsy), .gie(gie_q),
    .ints_q(ints_q), .inte_q(inte_q), .irq_q(irq)
  );

  always_ff @(posedge clk) begin
    if (eff_rst) begin
      ccr_q  <= '0;
      radr_q <= '0;
      data_q <= '0;
      line_q <= '0;
      dm_q   <= DM_RESET;
      cmd_q  <= '0;
      dar_q  <= '0;
    end else begin
      if (hit_ccr)  ccr_q  <= wdata[CCR_W-1:0];
      if (hit_line) line_q <= wdata[3:0];
      if (hit_dmod) dm_q   <= wdata[23:0];
      if (!start_q) begin
        if (hit_radr) radr_q <= wdata[RA_W-1:0];
        if (hit_data) data_q <= wdata;
        if (hit_cmd)  cmd_q  <= wdata[CMD_W-1:0];
        if (hit_dar)  dar_q  <= wdata[DAR_W-1:0];
      end
      if (done_ok && !xfer_err && xfer_rd_vld) data_q <= xfer_rdata;
    end
  end

  always_comb begin
    rmux = '0;
    case (addr)
      AW'(W_CTRL): begin
        rmux[C_START] = start_q;
        rmux[C_GIE]   = gie_q;
        rmux[C_SRST]  = srst_q;
      end
      AW'(W_CCR):  rmux = DW'(ccr_q);
      AW'(W_INTE): rmux = inte_q;
      AW'(W_INTS): rmux = ints_q;
      AW'(W_RADR): rmux = DW'(radr_q);
      AW'(W_DATA): rmux = data_q;
      AW'(W_LINE): rmux = DW'({scl_in, sda_in, line_q});
      AW'(W_DMOD): rmux = DW'({init_q, 7'd0, dm_q});
      AW'(W_CMD):  rmux = DW'(cmd_q);
      AW'(W_DAR):  rmux = DW'(dar_q);
      default:     rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rmux;
  end

  assign xfer_req     = start_q;
  assign xfer_abort   = abort_q;
  assign xfer_cmd     = cmd_q;
  assign xfer_regaddr = radr_q;
  assign xfer_rta     = dar_q[DAR_W-1:HWA_W];
  assign xfer_hwa     = dar_q[HWA_W-1:0];
  assign xfer_wdata   = data_q;
  assign init_req     = init_q;
  assign init_word    = dm_q;
  assign clk_div      = ccr_q[DIV_W-1:0];
  assign sda_dly      = ccr_q[CCR_W-1:DIV_W];
  assign sda_ovr_en   = line_q[0];
  assign sda_ovr_lvl  = line_q[1];
  assign scl_ovr_en   = line_q[2];
  assign scl_ovr_lvl  = line_q[3];
endmodule

// File: rtl/sbus_regif_chk.sv
module sbus_regif_chk #(
  parameter int AW          = 4,
  parameter int SRST_CYCLES = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          xfer_req,
  input logic          xfer_done,
  input logic          xfer_abort,
  input logic          init_req,
  input logic          init_done,
  input logic          irq,
  input logic          gie_q,
  input logic          srst_q,
  input logic          lbsy_flag
);
  logic [31:0] srst_run;
  logic        par_wr;

  assign par_wr = wr_en && (addr == AW'(4) || addr == AW'(7) || addr == AW'(11) || addr == AW'(12));

  always_ff @(posedge clk) begin
    if (rst) srst_run <= '0;
    else if (srst_q) srst_run <= srst_run + 1;
    else srst_run <= '0;
  end

  AST_START_DROPS_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && xfer_done && !(wr_en && addr == AW'(0))) |=> !xfer_req); // R2
  AST_LBSY_ON_BUSY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && par_wr && !srst_q) |=> lbsy_flag); // R5
  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    xfer_abort |=> !xfer_abort); // R6
  AST_ABORT_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    xfer_abort |-> !xfer_req); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(gie_q)); // R7
  AST_SRST_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    srst_q |-> (srst_run < 32'(SRST_CYCLES))); // R8
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (init_req && init_done && !(wr_en && addr == AW'(10))) |=> !init_req); // R9
endmodule

bind sbus_regif sbus_regif_chk #(.AW(AW), .SRST_CYCLES(SRST_CYCLES)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .xfer_req(xfer_req),
  .xfer_done(xfer_done), .xfer_abort(xfer_abort), .init_req(init_req),
  .init_done(init_done), .irq(irq), .gie_q(gie_q), .srst_q(srst_q),
  .lbsy_flag(ints_q[2])
);

// File: tb/sbus_regif_tb_top.sv
`timescale 1ns/1ps
module sbus_regif_tb_top;
  localparam logic [31:0] MASK = 32'h0001_0F07;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata, xfer_wdata, xfer_rdata = 0;
  logic irq, xfer_req, xfer_abort, init_req;
  logic [7:0] xfer_cmd, xfer_regaddr, xfer_rta, clk_div;
  logic [15:0] xfer_hwa;
  logic xfer_done = 0, xfer_err = 0, xfer_err_ack = 0, xfer_rd_vld = 0, init_done = 0;
  logic [3:0] xfer_err_data = 0;
  logic [23:0] init_word;
  logic [2:0] sda_dly;
  logic sda_ovr_en, sda_ovr_lvl, scl_ovr_en, scl_ovr_lvl;
  logic sda_in = 0, scl_in = 0;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  sbus_regif dut_i (.*);

  // behavioural reference model
  logic m_start, m_gie, m_srst, m_abort, m_init, m_irq;
  int m_scnt;
  logic [31:0] m_ints, m_inte, m_data, m_rdata;
  logic [10:0] m_ccr; logic [7:0] m_radr, m_cmd; logic [3:0] m_line;
  logic [23:0] m_dm, m_dar;

  function automatic logic [31:0] mread(input logic [3:0] a);
    case (a)
      0: return {24'd0, m_start, 5'd0, m_gie, m_srst};
      1: return {21'd0, m_ccr};
      2: return m_inte;
      3: return m_ints;
      4: return {24'd0, m_radr};
      7: return m_data;
      9: return {26'd0, scl_in, sda_in, m_line};
      10: return {m_init, 7'd0, m_dm};
      11: return {24'd0, m_cmd};
      12: return {8'd0, m_dar};
      default: return 0;
    endcase
  endfunction

  task automatic mclear();
    m_start = 0; m_gie = 0; m_abort = 0; m_init = 0; m_ints = 0; m_inte = 0;
    m_data = 0; m_ccr = 0; m_radr = 0; m_cmd = 0; m_line = 0; m_dm = 24'h7C3E00; m_dar = 0;
  endtask

  always @(posedge clk) begin
    logic st0, busy;
    logic [31:0] setv, clrv;
    if (rst) begin
      mclear(); m_srst = 0; m_scnt = 0; m_irq = 0; m_rdata = 0;
    end else begin
      if (rd_en) m_rdata = mread(addr);
      if (m_srst) begin
        mclear(); m_irq = 0;
        if (m_scnt == 3) begin m_srst = 0; m_scnt = 0; end else m_scnt++;
      end else begin
        m_irq = m_gie && ((m_ints & m_inte) != 0);
        st0 = m_start; m_abort = 0; setv = 0; clrv = 0;
        if (xfer_done && st0) begin
          m_start = 0; setv[0] = 1;
          if (xfer_err) begin setv[1] = 1; setv[11:8] = xfer_err_data; setv[16] = xfer_err_ack; end
          else if (xfer_rd_vld) m_data = xfer_rdata;
        end
        if (init_done && m_init) m_init = 0;
        busy = wr_en && st0 && (addr == 4 || addr == 7 || addr == 11 || addr == 12);
        if (wr_en) case (addr)
          0: if (wdata[0]) m_srst = 1;
             else begin
               m_gie = wdata[1];
               if (wdata[6]) begin m_start = 0; m_abort = 1; end
               else if (wdata[7]) m_start = 1;
             end
          1: m_ccr = wdata[10:0];
          2: m_inte = wdata & MASK;
          3: clrv = wdata & MASK;
          4: if (!st0) m_radr = wdata[7:0];
          7: if (!st0) m_data = wdata;
          9: m_line = wdata[3:0];
          10: begin m_dm = wdata[23:0]; if (wdata[31]) m_init = 1; end
          11: if (!st0) m_cmd = wdata[7:0];
          12: if (!st0) m_dar = wdata[23:0];
          default: ;
        endcase
        if (busy) setv[2] = 1;
        m_ints = (m_ints & ~clrv) | setv;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) if (!rst) begin
    check("R2 xfer_req vs model", {31'd0, xfer_req}, {31'd0, m_start});
    check("R6 xfer_abort vs model", {31'd0, xfer_abort}, {31'd0, m_abort});
    check("R7 irq vs model", {31'd0, irq}, {31'd0, m_irq});
    check("R9 init_req vs model", {31'd0, init_req}, {31'd0, m_init});
    check("R12 rdata vs model", rdata, m_rdata);
    check("R11 clk_div vs model", {24'd0, clk_div}, {24'd0, m_ccr[7:0]});
    check("R10 line outs vs model", {28'd0, scl_ovr_lvl, scl_ovr_en, sda_ovr_lvl, sda_ovr_en},
          {28'd0, m_line});
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    check(tag, rdata, exp);
  endtask

  task automatic done(input logic e, input logic [3:0] db, input logic ack,
                      input logic rv, input logic [31:0] rdat);
    @(negedge clk);
    xfer_done = 1; xfer_err = e; xfer_err_data = db; xfer_err_ack = ack;
    xfer_rd_vld = rv; xfer_rdata = rdat;
    @(negedge clk);
    xfer_done = 0; xfer_err = 0; xfer_err_data = 0; xfer_err_ack = 0; xfer_rd_vld = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(0, 32'h0, "R1 control after reset");
    rd(10, 32'h007C3E00, "R1 device-mode after reset");
    rd(3, 32'h0, "R1 status after reset");
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    // R11 clock control
    wr(1, 32'hFFFF_FFFF);
    rd(1, 32'h0000_07FF, "R11 clock control readback");
    check("R11 clk_div", {24'd0, clk_div}, 32'hFF);
    check("R11 sda_dly", {29'd0, sda_dly}, 32'h7);
    // R10 line control
    wr(9, 32'h0000_0005);
    check("R10 sda_ovr_en", {31'd0, sda_ovr_en}, 32'd1);
    check("R10 scl_ovr_en", {31'd0, scl_ovr_en}, 32'd1);
    check("R10 sda_ovr_lvl", {31'd0, sda_ovr_lvl}, 32'd0);
    scl_in = 1; sda_in = 0;
    rd(9, 32'h0000_0025, "R10 line readback with scl high");
    // R2, R5, R12 read transfer
    wr(4, 32'h55); wr(12, 32'h002D_03A3); wr(11, 32'h8B); wr(7, 32'h1234);
    wr(0, 32'h80);
    check("R2 xfer_req after start", {31'd0, xfer_req}, 32'd1);
    check("R2 hwa out", {16'd0, xfer_hwa}, 32'h03A3);
    check("R2 rta out", {24'd0, xfer_rta}, 32'h2D);
    rd(0, 32'h80, "R2 start reads one while running");
    wr(7, 32'hDEAD);
    wr(11, 32'h4E);
    rd(7, 32'h1234, "R5 data kept during busy write");
    check("R5 cmd kept during busy write", {24'd0, xfer_cmd}, 32'h8B);
    rd(3, 32'h4, "R5 load busy flag");
    done(0, 0, 0, 1, 32'hCAFE_F00D);
    rd(0, 32'h0, "R2 start self-cleared");
    rd(3, 32'h5, "R2 done flag set");
    rd(7, 32'hCAFE_F00D, "R12 read data loaded");
    // R4 W1C
    wr(3, 32'h1);
    rd(3, 32'h4, "R4 clear only done");
    wr(3, 32'hFFFF_FFFF);
    rd(3, 32'h0, "R4 clear all");
    // R3 and R7 error with interrupt
    wr(2, 32'hFFFF_FFFF);
    rd(2, 32'h0001_0F07, "R7 enable stores implemented bits");
    wr(0, 32'h82);
    done(1, 4'h3, 1, 1, 32'h1111_1111);
    rd(3, 32'h0001_0303, "R3 error fields");
    rd(7, 32'hCAFE_F00D, "R12 no load on error");
    check("R7 irq high", {31'd0, irq}, 32'd1);
    wr(0, 32'h0);
    idle(2);
    check("R7 irq low without global enable", {31'd0, irq}, 32'd0);
    wr(3, 32'hFFFF_FFFF);
    // R4 hardware set beats same-cycle clear
    wr(0, 32'h80);
    @(negedge clk); wr_en = 1; addr = 3; wdata = 32'h1; xfer_done = 1;
    @(negedge clk); wr_en = 0; xfer_done = 0;
    rd(3, 32'h1, "R4 set wins over clear");
    wr(3, 32'h1);
    // R6 abort
    wr(0, 32'h80);
    @(negedge clk); wr_en = 1; addr = 0; wdata = 32'h40;
    @(negedge clk); wr_en = 0;
    check("R6 abort pulse", {31'd0, xfer_abort}, 32'd1);
    check("R6 request dropped", {31'd0, xfer_req}, 32'd0);
    @(negedge clk);
    check("R6 abort one cycle", {31'd0, xfer_abort}, 32'd0);
    rd(3, 32'h0, "R6 no status on abort");
    // R9 init
    wr(10, 32'h807C_3E00);
    check("R9 init_req high", {31'd0, init_req}, 32'd1);
    check("R9 init_word", {8'd0, init_word}, 32'h7C3E00);
    rd(10, 32'h807C_3E00, "R9 go bit reads one");
    @(negedge clk); init_done = 1; @(negedge clk); init_done = 0;
    rd(10, 32'h007C_3E00, "R9 go bit cleared");
    // R8 soft reset
    wr(1, 32'h12); wr(0, 32'h2);
    wr(0, 32'h1);
    rd(0, 32'h1, "R8 soft reset bit reads one");
    wr(1, 32'h55);
    idle(4);
    rd(0, 32'h0, "R8 soft reset bit cleared");
    rd(1, 32'h0, "R8 register cleared and write dropped");
    rd(10, 32'h007C3E00, "R8 device-mode back to reset value");
    // R12 unmapped
    rd(5, 32'h0, "R12 unmapped offset");
    idle(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule